// File: doc/BRIEF.md
# Staged Control Word Loader

This block lets a host with a narrow bus write wide configuration words into a bank of control registers. The host bus has an 8-bit data path, a 3-bit register address and one write strobe. The host places four bytes into holding registers and then writes an 8-bit target index. A fixed number of clocks later, the block copies the assembled 32-bit word into the selected control register.

The write strobe comes from the host side and is not tied to the block clock. It passes through a two-stage synchronizer. Its rising edge then produces a single capture pulse, and the address and data lines are sampled on that pulse. The host must hold the address and data steady while the strobe is high.

The holding registers keep their contents after a transfer. A host that loads a series of similar words therefore only needs to rewrite the bytes that change. While a transfer is pending the block raises a busy flag, and any new index write is dropped. All control registers appear side by side on one flat output bus.

Top module: `ctlword_loader`

## Requirements
- R1: A capture at bus address 0, 1, 2 or 3 stores the data byte into holding byte 0, 1, 2 or 3. Holding byte k supplies bits 8k+7 down to 8k of the transferred 32-bit word.
- R2: A capture happens on the third rising clock edge at which `hst_we` is sampled high after being sampled low. Exactly one capture occurs for each rising edge of the strobe, however long the strobe stays high.
- R3: A capture at bus address 4 takes all 8 data bits as the target index. Target t occupies bits 32t+31 down to 32t of `ctl_words`.
- R4: The holding word is written into the target register on the fourth rising clock edge after the index capture edge. No target register changes at any other time.
- R5: Writing bytes 38h, D0h, 18h and 00h to addresses 0 to 3, then 00h to address 4, leaves target 0 holding 0018D038h.
- R6: `busy` is high for exactly four clock cycles, starting after the index capture edge. An address-4 capture while `busy` is high is ignored: no target changes and no new transfer starts.
- R7: The holding bytes keep their values after a transfer. A later transfer that rewrites only one byte carries the other three bytes unchanged.
- R8: Reset clears the holding bytes, the target index, `busy` and every target register to zero.
- R9: A capture at bus address 5, 6 or 7 changes no holding byte, no target register and `busy`.
- R10: A target index of `NUM_TARGETS` or higher still runs the busy sequence, but changes no target register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_we | input | 1 | Host write strobe, asynchronous; its rising edge writes |
| hst_addr | input | 3 | Host register address |
| hst_data | input | 8 | Host write data |
| busy | output | 1 | High while a transfer is pending |
| ctl_words | output | NUM_TARGETS*32 | All target registers; target t in bits 32t+31:32t |

## Verification
The known-answer load of 0018D038h into target 0 shows that the byte lanes are ordered correctly. A load of four distinct bytes into the highest target shows the lane order and the decoding of the top index. Rewriting a single byte before a second load shows whether the holding bytes are retained or cleared. A strobe held high for many cycles separates edge detection from level sensing. A second index write fired quickly into the busy window shows whether that write is dropped or overrides the first. Writes to the unused addresses and to an index beyond the bank show whether stray writes leak into any register. Throughout the run, a clock-by-clock reference model of all target registers and the busy flag pins down the exact transfer cycle.

// File: rtl/ctlword_pkg.sv
package ctlword_pkg;
   localparam int unsigned BUS_AW      = 3;
   localparam int unsigned BUS_DW      = 8;
   localparam int unsigned BYTES_PER_W = 4;
   localparam int unsigned WORD_W      = BUS_DW * BYTES_PER_W;
   localparam logic [BUS_AW-1:0] ADDR_INDEX = 3'd4;

   typedef logic [BUS_DW-1:0] bus_byte_t;
   typedef logic [WORD_W-1:0] ctl_word_t;

   typedef enum logic {XF_IDLE = 1'b0, XF_WAIT = 1'b1} xfer_state_e;
endpackage

// File: rtl/ctlword_strobe_sync.sv
module ctlword_strobe_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_async,
   output logic pulse
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_async};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign pulse = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/ctlword_holding.sv
module ctlword_holding
   import ctlword_pkg::*;
#(
   parameter int unsigned NUM_BYTES = BYTES_PER_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_pulse,
   input  logic [BUS_AW-1:0]       wr_addr,
   input  bus_byte_t               wr_data,
   output logic [NUM_BYTES*BUS_DW-1:0] word
);
   generate
      if (NUM_BYTES > 4) begin : g_bad
         $error("NUM_BYTES exceeds the holding address range");
      end
      for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
         bus_byte_t byte_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               byte_q <= '0;
            end else if (wr_pulse && wr_addr == BUS_AW'(b)) begin
               byte_q <= wr_data;
            end
         end
         assign word[b*BUS_DW +: BUS_DW] = byte_q;
      end
   endgenerate
endmodule

// File: rtl/ctlword_xfer_seq.sv
module ctlword_xfer_seq
   import ctlword_pkg::*;
#(
   parameter int unsigned XFER_DELAY = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  bus_byte_t idx_in,
   output logic      busy,
   output logic      commit,
   output bus_byte_t commit_idx
);
   localparam int unsigned CNT_W = (XFER_DELAY > 1) ? $clog2(XFER_DELAY) : 1;

   generate
      if (XFER_DELAY < 1) begin : g_bad
         $error("XFER_DELAY must be at least 1");
      end
   endgenerate

   xfer_state_e      state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= XF_IDLE;
         cnt_q      <= '0;
         commit_idx <= '0;
      end else begin
         case (state_q)
            XF_IDLE: if (start) begin
               state_q    <= XF_WAIT;
               cnt_q      <= CNT_W'(XFER_DELAY - 1);
               commit_idx <= idx_in;
            end
            XF_WAIT: if (cnt_q == '0) begin
               state_q <= XF_IDLE;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
            default: state_q <= XF_IDLE;
         endcase
      end
   end

   assign busy   = (state_q == XF_WAIT);
   assign commit = busy && (cnt_q == '0);
endmodule

// File: rtl/ctlword_target_bank.sv
module ctlword_target_bank
   import ctlword_pkg::*;
#(
   parameter int unsigned NUM_TARGETS = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          commit,
   input  bus_byte_t                     idx,
   input  ctl_word_t                     word,
   output logic [NUM_TARGETS*WORD_W-1:0] words
);
   generate
      if (NUM_TARGETS < 1 || NUM_TARGETS > 256) begin : g_bad
         $error("NUM_TARGETS must be between 1 and 256");
      end
      for (genvar t = 0; t < NUM_TARGETS; t++) begin : g_tgt
         ctl_word_t reg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               reg_q <= '0;
            end else if (commit && 32'(idx) == t) begin
               reg_q <= word;
            end
         end
         assign words[t*WORD_W +: WORD_W] = reg_q;
      end
   endgenerate
endmodule

// File: rtl/ctlword_loader.sv
module ctlword_loader
   import ctlword_pkg::*;
#(
   parameter int unsigned NUM_TARGETS = 16,
   parameter int unsigned XFER_DELAY  = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          hst_we,
   input  logic [2:0]                    hst_addr,
   input  logic [7:0]                    hst_data,
   output logic                          busy,
   output logic [NUM_TARGETS*32-1:0]     ctl_words
);
   logic      cap_pulse;
   logic      start;
   logic      commit;
   bus_byte_t commit_idx;
   ctl_word_t hold_word;

   ctlword_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .strobe_async(hst_we), .pulse(cap_pulse)
   );

   ctlword_holding #(.NUM_BYTES(BYTES_PER_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr_pulse(cap_pulse),
      .wr_addr(hst_addr), .wr_data(hst_data), .word(hold_word)
   );

   assign start = cap_pulse && (hst_addr == ADDR_INDEX);

   ctlword_xfer_seq #(.XFER_DELAY(XFER_DELAY)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .idx_in(hst_data),
      .busy(busy), .commit(commit), .commit_idx(commit_idx)
   );

   ctlword_target_bank #(.NUM_TARGETS(NUM_TARGETS)) u_bank (
      .clk(clk), .rst_n(rst_n), .commit(commit), .idx(commit_idx),
      .word(hold_word), .words(ctl_words)
   );
endmodule

// File: rtl/ctlword_loader_chk.sv
module ctlword_loader_chk #(
   parameter int unsigned NUM_TARGETS = 16,
   parameter int unsigned XFER_DELAY  = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      cap_pulse,
   input logic [2:0]                hst_addr,
   input logic                      busy,
   input logic [7:0]                commit_idx,
   input logic [31:0]               hold_word,
   input logic [NUM_TARGETS*32-1:0] ctl_words
);
   logic [15:0] busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_run <= '0;
      else if (busy) busy_run <= (busy_run == 16'hFFFF) ? busy_run : busy_run + 1'b1;
      else busy_run <= '0;
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_pulse |=> !cap_pulse); // R2

   AST_BUSY_FROM_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cap_pulse && hst_addr == 3'd4)); // R3

   AST_BANK_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_words != $past(ctl_words)) |-> $fell(busy)); // R4

   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> busy_run == 16'(XFER_DELAY)); // R6

   AST_INDEX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(commit_idx)); // R6

   AST_UNUSED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_pulse && hst_addr >= 3'd5 && !busy) |=> $stable(hold_word) && !busy); // R9
endmodule

bind ctlword_loader ctlword_loader_chk #(.NUM_TARGETS(NUM_TARGETS), .XFER_DELAY(XFER_DELAY)) u_chk (
   .clk(clk), .rst_n(rst_n), .cap_pulse(cap_pulse), .hst_addr(hst_addr),
   .busy(busy), .commit_idx(commit_idx), .hold_word(hold_word), .ctl_words(ctl_words)
);

// File: tb/ctlword_loader_test.sv
module ctlword_loader_test;
   localparam int NT = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              hst_we = 1'b0;
   logic [2:0]        hst_addr = '0;
   logic [7:0]        hst_data = '0;
   logic              busy;
   logic [NT*32-1:0]  ctl_words;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   ctlword_loader #(.NUM_TARGETS(NT)) uut (
      .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr),
      .hst_data(hst_data), .busy(busy), .ctl_words(ctl_words)
   );

   // behavioural reference model
   logic [31:0] m_bank [NT];
   logic [7:0]  m_hold [4];
   int          m_idx, m_left;
   bit          m_busy;
   bit          wr_hist [$] = '{0, 0, 0};

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_bank[i]) m_bank[i] = '0;
         foreach (m_hold[i]) m_hold[i] = '0;
         m_idx = 0; m_left = 0; m_busy = 0;
         wr_hist = '{0, 0, 0};
      end else begin
         bit was_busy;
         bit capture;
         was_busy = m_busy;
         capture  = wr_hist[1] && !wr_hist[2];
         if (m_busy) begin
            if (m_left == 0) begin
               if (m_idx < NT) m_bank[m_idx] = {m_hold[3], m_hold[2], m_hold[1], m_hold[0]};
               m_busy = 0;
            end else m_left--;
         end
         if (capture) begin
            if (hst_addr < 4) m_hold[hst_addr] = hst_data;
            else if (hst_addr == 4 && !was_busy) begin
               m_idx = hst_data; m_busy = 1; m_left = 3;
            end
         end
         wr_hist.push_front(hst_we);
         void'(wr_hist.pop_back());
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] word_of(input int t);
      return ctl_words[t*32 +: 32];
   endfunction

   // per-clock comparison against the model; busy-length and rise counting
   int run = 0;
   int busy_rises = 0;
   bit prev_busy = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         check(busy == m_busy, "R6 busy vs model", 32'(busy), 32'(m_busy));
         for (int t = 0; t < NT; t++)
            check(word_of(t) == m_bank[t], "R4 target vs model", word_of(t), m_bank[t]);
         if (busy) run++;
         else if (run != 0) begin
            check(run == 4, "R4 busy window length", run, 4);
            run = 0;
         end
         if (busy && !prev_busy) busy_rises++;
         prev_busy = busy;
      end
   end

   task automatic host_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); hst_addr = a; hst_data = d; hst_we = 1'b1;
      repeat (4) @(negedge clk);
      hst_we = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   bit done = 0;
   initial begin
      for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      wait_clks(4);
      // R8: reset state
      check(busy == 1'b0, "R8 busy after reset", 32'(busy), 0);
      for (int t = 0; t < NT; t++) check(word_of(t) == 0, "R8 target after reset", word_of(t), 0);
      rst_n = 1'b1;
      wait_clks(2);

      // R5 / R1: known-answer load into target 0
      host_write(3'd0, 8'h38); host_write(3'd1, 8'hD0);
      host_write(3'd2, 8'h18); host_write(3'd3, 8'h00);
      host_write(3'd4, 8'h00); wait_clks(4);
      check(word_of(0) == 32'h0018D038, "R5 target 0 known answer", word_of(0), 32'h0018D038);

      // R7: rewrite only byte 2, load into target 5
      host_write(3'd2, 8'hAA); host_write(3'd4, 8'd5); wait_clks(4);
      check(word_of(5) == 32'h00AAD038, "R7 retained bytes", word_of(5), 32'h00AAD038);
      check(word_of(0) == 32'h0018D038, "R7 target 0 untouched", word_of(0), 32'h0018D038);

      // R1 / R3: distinct lanes into the highest target
      host_write(3'd0, 8'h11); host_write(3'd1, 8'h22);
      host_write(3'd2, 8'h33); host_write(3'd3, 8'h44);
      host_write(3'd4, 8'(NT-1)); wait_clks(4);
      check(word_of(NT-1) == 32'h44332211, "R1 R3 lane order top target", word_of(NT-1), 32'h44332211);

      // R10: out-of-range index changes nothing
      host_write(3'd4, 8'd200); wait_clks(4);
      check(word_of(0) == 32'h0018D038 && word_of(5) == 32'h00AAD038 && word_of(NT-1) == 32'h44332211,
            "R10 out-of-range index", word_of(0), 32'h0018D038);

      // R9: unused addresses
      host_write(3'd5, 8'hFF); host_write(3'd6, 8'hEE); host_write(3'd7, 8'hDD);
      check(busy == 1'b0, "R9 busy after unused writes", 32'(busy), 0);
      host_write(3'd4, 8'd2); wait_clks(4);
      check(word_of(2) == 32'h44332211, "R9 holding unchanged", word_of(2), 32'h44332211);

      // R6: second index write inside the busy window
      @(negedge clk); hst_addr = 3'd4; hst_data = 8'd3; hst_we = 1'b1;
      wait_clks(2); hst_we = 1'b0; wait_clks(1);
      hst_data = 8'd7; hst_we = 1'b1;
      wait_clks(3);
      check(busy == 1'b1, "R6 busy during second capture", 32'(busy), 1);
      hst_we = 1'b0; wait_clks(10);
      check(word_of(3) == 32'h44332211, "R6 first index taken", word_of(3), 32'h44332211);
      check(word_of(7) == 32'h0, "R6 second index ignored", word_of(7), 0);

      // R2: long strobe gives one capture
      begin
         int rises_before;
         rises_before = busy_rises;
         @(negedge clk); hst_addr = 3'd4; hst_data = 8'd1; hst_we = 1'b1;
         wait_clks(30); hst_we = 1'b0; wait_clks(6);
         check(busy_rises - rises_before == 1, "R2 one transfer per strobe",
               busy_rises - rises_before, 1);
         check(word_of(1) == 32'h44332211, "R2 target 1 loaded", word_of(1), 32'h44332211);
      end

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule